// File: doc/BRIEF.md
# Programmable Clock Post-Divider and Output Router

This block is the digital output stage of a configurable clock generator. It receives a reference clock and a synthesized clock, both as levels that it samples with a fast system clock. It produces a main clock and a secondary clock, and each one has its own output-enable that stands in for a tri-state driver. A post-divider divides its source by twice a programmed value. Per-output source selects choose among the raw reference, the divided clocks and half-rate copies.

Two configuration banks hold the complete set of settings: the post-divide value, the pre-divide and feedback-divide settings handed to the external loop, and the two source selects. A single multifunction pin, whose role is set by a static mode input, acts as one of four things: an enable input, a sleep input, a bank-select input, or the pin that carries the secondary clock. Bank switches and source changes are applied only while the output they affect is low, so a reconfiguration never cuts a high pulse short.

Top module: `clkrt_top`

## Requirements
- R1: With post-divide value P of 1 or more, a divided clock toggles on every P-th rising edge of its source level. Its period is therefore 2·P source periods, high for exactly half of them.
- R2: A post-divide value of 0 behaves exactly like a value of 1.
- R3: The main source select takes these values: 0 or 3 = synthesized clock divided by 2·P, 1 = raw reference, 2 = reference divided by 2·P. `main_clk` follows the chosen source two system-clock edges after the input level.
- R4: The secondary source select takes these values: 0 = raw reference, 1 = reference divided by 2, 2 = main clock, 3 = main clock divided by 2. `aux_clk_en` is 1 only in pin mode 3.
- R5: Pin mode encoding is 0 = enable, 1 = sleep, 2 = bank select, 3 = secondary clock. In mode 0, a low pin drives `main_clk_en` to 0 one edge after the pin is sampled, and a high pin drives it to 1.
- R6: In mode 1, a low pin raises `pll_sleep`, drops both enables, holds both clocks low and clears every divider. On release, both clocks start low and the dividers count from zero.
- R7: In mode 2 the pin level picks the active bank (0 or 1). `active_bank`, `pll_pre_div` and `pll_fb_div` follow that bank. The change is taken only on an edge where `main_clk` is low.
- R8: A change of either source select takes effect only on an edge where the affected output is low.
- R9: In every mode other than 2, the requested bank is 1. In mode 3 the pin level changes neither enable, sleep nor bank.
- R10: After reset both clocks are low, `active_bank` is 1 and `pll_sleep` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference clock level |
| syn_in | input | 1 | Synthesized clock level |
| mf_mode | input | 2 | Multifunction pin role |
| mf_pin | input | 1 | Multifunction pin input level |
| b0_post_div | input | 14 | Bank 0 post-divide value P |
| b0_pre_div | input | 5 | Bank 0 reference pre-divide setting |
| b0_fb_div | input | 8 | Bank 0 feedback divide setting |
| b0_main_sel | input | 2 | Bank 0 main source select |
| b0_aux_sel | input | 2 | Bank 0 secondary source select |
| b1_post_div | input | 14 | Bank 1 post-divide value P |
| b1_pre_div | input | 5 | Bank 1 reference pre-divide setting |
| b1_fb_div | input | 8 | Bank 1 feedback divide setting |
| b1_main_sel | input | 2 | Bank 1 main source select |
| b1_aux_sel | input | 2 | Bank 1 secondary source select |
| main_clk | output | 1 | Main clock output |
| main_clk_en | output | 1 | Main output enable (0 = high impedance) |
| aux_clk | output | 1 | Secondary clock on the multifunction pin |
| aux_clk_en | output | 1 | Secondary output enable |
| pll_pre_div | output | 5 | Active pre-divide setting for the loop |
| pll_fb_div | output | 8 | Active feedback divide setting for the loop |
| pll_sleep | output | 1 | Sleep request to the loop and oscillator |
| active_bank | output | 1 | Bank currently applied |

## Verification
The bench builds the block with its default widths: a 14-bit post-divide field, a 5-bit pre-divide field and an 8-bit feedback field. Post-divide values stay between 0 and 3, and the reference and synthesized levels toggle every 2 and 3 system cycles. With those settings a whole number of output periods fits in windows of a few hundred cycles, so duty cycle and rising-edge counts can be checked exactly. The short periods also let random bank flips and source changes land often at both output phases, which puts the low-phase switching rule under real stress.

// File: rtl/clkrt_pkg.sv
package clkrt_pkg;

    localparam int POST_W = 14;
    localparam int PRE_W  = 5;
    localparam int FB_W   = 8;

    typedef enum logic [1:0] {
        MF_ENABLE  = 2'd0,
        MF_SLEEP   = 2'd1,
        MF_BANKSEL = 2'd2,
        MF_AUXCLK  = 2'd3
    } mf_mode_e;

    typedef enum logic [1:0] {
        MS_SYN_DIV  = 2'd0,
        MS_REF      = 2'd1,
        MS_REF_DIV  = 2'd2,
        MS_SYN_DIV3 = 2'd3
    } main_src_e;

    typedef enum logic [1:0] {
        AS_REF       = 2'd0,
        AS_REF_HALF  = 2'd1,
        AS_MAIN      = 2'd2,
        AS_MAIN_HALF = 2'd3
    } aux_src_e;

    typedef struct packed {
        logic out_en;
        logic sleep;
        logic bank_req;
        logic aux_drv;
    } pin_ctl_t;

    function automatic logic [POST_W-1:0] eff_post(input logic [POST_W-1:0] p);
        return (p == '0) ? POST_W'(1) : p;
    endfunction

endpackage

// File: rtl/clkrt_pin_ctl.sv
module clkrt_pin_ctl
    import clkrt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  mf_mode_e mode,
    input  logic     pin,
    output pin_ctl_t ctl
);

    logic pin_q;

    always_ff @(posedge clk) begin
        if (rst) pin_q <= 1'b1;
        else     pin_q <= pin;
    end

    always_comb begin
        ctl.out_en   = (mode == MF_ENABLE)  ? pin_q : 1'b1;
        ctl.sleep    = (mode == MF_SLEEP)   & ~pin_q;
        ctl.bank_req = (mode == MF_BANKSEL) ? pin_q : 1'b1;
        ctl.aux_drv  = (mode == MF_AUXCLK);
    end

endmodule

// File: rtl/clkrt_div2p.sv
module clkrt_div2p #(
    parameter int CNT_W = clkrt_pkg::POST_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             lvl,
    input  logic [CNT_W-1:0] p_eff,
    output logic             div_q
);

    logic             lvl_d;
    logic             rise;
    logic [CNT_W-1:0] cnt;

    assign rise = lvl & ~lvl_d;

    always_ff @(posedge clk) begin
        if (rst) lvl_d <= 1'b0;
        else     lvl_d <= lvl;
    end

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt   <= '0;
            div_q <= 1'b0;
        end else if (rise) begin
            if (cnt >= p_eff - CNT_W'(1)) begin
                cnt   <= '0;
                div_q <= ~div_q;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    // R1: the divided level only moves after a source rising edge
    p_toggle_on_edge_r1: assert property (@(posedge clk) disable iff (rst)
        (!$stable(div_q) && !$past(hold) && !$past(rst)) |-> $past(rise));

    // R1: every toggle restarts the count
    p_count_restart_r1: assert property (@(posedge clk) disable iff (rst)
        (!$stable(div_q) && !$past(hold) && !$past(rst)) |-> (cnt == '0));

endmodule

// File: rtl/clkrt_route.sv
module clkrt_route
    import clkrt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      hold,
    input  main_src_e main_want,
    input  aux_src_e  aux_want,
    input  logic      syn_div,
    input  logic      ref_lvl,
    input  logic      ref_div,
    input  logic      ref_half,
    input  logic      main_half,
    output logic      main_q,
    output logic      aux_q
);

    main_src_e main_act;
    aux_src_e  aux_act;
    logic      main_c;
    logic      aux_c;

    always_comb begin
        case (main_act)
            MS_REF:     main_c = ref_lvl;
            MS_REF_DIV: main_c = ref_div;
            default:    main_c = syn_div;
        endcase
    end

    always_comb begin
        case (aux_act)
            AS_REF:      aux_c = ref_lvl;
            AS_REF_HALF: aux_c = ref_half;
            AS_MAIN:     aux_c = main_q;
            default:     aux_c = main_half;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            main_act <= MS_SYN_DIV;
            aux_act  <= AS_REF;
            main_q   <= 1'b0;
            aux_q    <= 1'b0;
        end else begin
            if (!main_q) main_act <= main_want;
            if (!aux_q)  aux_act  <= aux_want;
            main_q <= main_c;
            aux_q  <= aux_c;
        end
    end

    // R8: the main selection only moves while the main output is low
    p_main_sel_low_r8: assert property (@(posedge clk) disable iff (rst || hold)
        (!$stable(main_act) && !$past(hold) && !$past(rst)) |-> !$past(main_q));

    // R8: the secondary selection only moves while its output is low
    p_aux_sel_low_r8: assert property (@(posedge clk) disable iff (rst || hold)
        (!$stable(aux_act) && !$past(hold) && !$past(rst)) |-> !$past(aux_q));

endmodule

// File: rtl/clkrt_top.sv
module clkrt_top #(
    parameter int POST_W = clkrt_pkg::POST_W,
    parameter int PRE_W  = clkrt_pkg::PRE_W,
    parameter int FB_W   = clkrt_pkg::FB_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_in,
    input  logic              syn_in,
    input  logic [1:0]        mf_mode,
    input  logic              mf_pin,
    input  logic [POST_W-1:0] b0_post_div,
    input  logic [PRE_W-1:0]  b0_pre_div,
    input  logic [FB_W-1:0]   b0_fb_div,
    input  logic [1:0]        b0_main_sel,
    input  logic [1:0]        b0_aux_sel,
    input  logic [POST_W-1:0] b1_post_div,
    input  logic [PRE_W-1:0]  b1_pre_div,
    input  logic [FB_W-1:0]   b1_fb_div,
    input  logic [1:0]        b1_main_sel,
    input  logic [1:0]        b1_aux_sel,
    output logic              main_clk,
    output logic              main_clk_en,
    output logic              aux_clk,
    output logic              aux_clk_en,
    output logic [PRE_W-1:0]  pll_pre_div,
    output logic [FB_W-1:0]   pll_fb_div,
    output logic              pll_sleep,
    output logic              active_bank
);
    import clkrt_pkg::*;

    localparam int N_DIV   = 4;
    localparam int D_SYN   = 0;
    localparam int D_REF   = 1;
    localparam int D_RHALF = 2;
    localparam int D_MHALF = 3;

    logic              ref_s;
    logic              syn_s;
    pin_ctl_t          ctl;
    logic              bank_act;
    logic [POST_W-1:0] post_act;
    logic [POST_W-1:0] post_eff;
    main_src_e         main_want;
    aux_src_e          aux_want;
    logic              main_q;
    logic              aux_q;
    logic [N_DIV-1:0]  div_lvl;
    logic [N_DIV-1:0]  div_q;
    logic [POST_W-1:0] div_p [N_DIV];

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_s <= 1'b0;
            syn_s <= 1'b0;
        end else begin
            ref_s <= ref_in;
            syn_s <= syn_in;
        end
    end

    clkrt_pin_ctl u_pin (
        .clk  (clk),
        .rst  (rst),
        .mode (mf_mode_e'(mf_mode)),
        .pin  (mf_pin),
        .ctl  (ctl)
    );

    always_ff @(posedge clk) begin
        if (rst)          bank_act <= 1'b1;
        else if (!main_q) bank_act <= ctl.bank_req;
    end

    always_comb begin
        post_act    = bank_act ? b1_post_div : b0_post_div;
        main_want   = main_src_e'(bank_act ? b1_main_sel : b0_main_sel);
        aux_want    = aux_src_e'(bank_act ? b1_aux_sel : b0_aux_sel);
        pll_pre_div = bank_act ? b1_pre_div : b0_pre_div;
        pll_fb_div  = bank_act ? b1_fb_div : b0_fb_div;
    end

    assign post_eff = eff_post(post_act);

    always_comb begin
        div_lvl          = '0;
        div_lvl[D_SYN]   = syn_s;
        div_lvl[D_REF]   = ref_s;
        div_lvl[D_RHALF] = ref_s;
        div_lvl[D_MHALF] = main_q;
        div_p[D_SYN]     = post_eff;
        div_p[D_REF]     = post_eff;
        div_p[D_RHALF]   = POST_W'(1);
        div_p[D_MHALF]   = POST_W'(1);
    end

    generate
        for (genvar g = 0; g < N_DIV; g++) begin : g_div
            clkrt_div2p #(.CNT_W(POST_W)) u_div (
                .clk   (clk),
                .rst   (rst),
                .hold  (ctl.sleep),
                .lvl   (div_lvl[g]),
                .p_eff (div_p[g]),
                .div_q (div_q[g])
            );
        end
    endgenerate

    clkrt_route u_route (
        .clk       (clk),
        .rst       (rst),
        .hold      (ctl.sleep),
        .main_want (main_want),
        .aux_want  (aux_want),
        .syn_div   (div_q[D_SYN]),
        .ref_lvl   (ref_s),
        .ref_div   (div_q[D_REF]),
        .ref_half  (div_q[D_RHALF]),
        .main_half (div_q[D_MHALF]),
        .main_q    (main_q),
        .aux_q     (aux_q)
    );

    assign main_clk    = main_q;
    assign aux_clk     = aux_q;
    assign main_clk_en = ctl.out_en & ~ctl.sleep;
    assign aux_clk_en  = ctl.aux_drv;
    assign pll_sleep   = ctl.sleep;
    assign active_bank = bank_act;

    // R6: one edge after sleep is seen both clocks sit low
    p_sleep_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        pll_sleep |=> (!main_clk && !aux_clk));

    // R6: leaving sleep always starts from low outputs
    p_sleep_exit_low_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(pll_sleep) |-> (!main_clk && !aux_clk));

    // R7: bank changes are taken only during a low main phase
    p_bank_low_r7: assert property (@(posedge clk) disable iff (rst)
        (!$stable(bank_act) && !$past(rst)) |-> !$past(main_q));

    // R9: driving the secondary clock leaves the other pin roles at their defaults
    p_aux_defaults_r9: assert property (@(posedge clk) disable iff (rst)
        aux_clk_en |-> (main_clk_en && !pll_sleep));

endmodule

// File: tb/clkrt_top_tb.sv
module clkrt_top_tb;

    localparam int CLK_P  = 10;
    localparam int POST_W = 14;
    localparam int PRE_W  = 5;
    localparam int FB_W   = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_in = 1'b0;
    logic syn_in = 1'b0;
    logic [1:0] mf_mode = 2'd0;
    logic mf_pin = 1'b1;
    logic [POST_W-1:0] b0_post = 14'd1;
    logic [PRE_W-1:0]  b0_pre = 5'd3;
    logic [FB_W-1:0]   b0_fb = 8'd40;
    logic [1:0]        b0_msel = 2'd2;
    logic [1:0]        b0_asel = 2'd0;
    logic [POST_W-1:0] b1_post = 14'd3;
    logic [PRE_W-1:0]  b1_pre = 5'd17;
    logic [FB_W-1:0]   b1_fb = 8'd200;
    logic [1:0]        b1_msel = 2'd2;
    logic [1:0]        b1_asel = 2'd0;

    logic main_clk, main_clk_en, aux_clk, aux_clk_en, pll_sleep, active_bank;
    logic [PRE_W-1:0] pll_pre_div;
    logic [FB_W-1:0]  pll_fb_div;

    int n_chk = 0;
    int n_fail = 0;
    bit ended = 0;
    int ref_hp = 2;
    int syn_hp = 3;

    always #(CLK_P/2) clk = ~clk;

    clkrt_top u_dut (
        .clk(clk), .rst(rst), .ref_in(ref_in), .syn_in(syn_in),
        .mf_mode(mf_mode), .mf_pin(mf_pin),
        .b0_post_div(b0_post), .b0_pre_div(b0_pre), .b0_fb_div(b0_fb),
        .b0_main_sel(b0_msel), .b0_aux_sel(b0_asel),
        .b1_post_div(b1_post), .b1_pre_div(b1_pre), .b1_fb_div(b1_fb),
        .b1_main_sel(b1_msel), .b1_aux_sel(b1_asel),
        .main_clk(main_clk), .main_clk_en(main_clk_en),
        .aux_clk(aux_clk), .aux_clk_en(aux_clk_en),
        .pll_pre_div(pll_pre_div), .pll_fb_div(pll_fb_div),
        .pll_sleep(pll_sleep), .active_bank(active_bank)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // source clock levels, moved 3 time units after each edge
    int rc = 0;
    int sc = 0;
    always @(posedge clk) begin
        #3;
        rc++;
        if (rc >= ref_hp) begin rc = 0; ref_in = ~ref_in; end
        sc++;
        if (sc >= syn_hp) begin sc = 0; syn_in = ~syn_in; end
    end

    // behavioural reference model, advanced on every edge
    int m_pin = 1, m_rs = 0, m_rp = 0, m_ss = 0, m_sp = 0;
    int m_rcnt = 0, m_rdiv = 0, m_scnt = 0, m_sdiv = 0, m_rh = 0, m_mh = 0, m_mcnt = 0;
    int m_c0 = 0, m_c0p = 0, m_c1 = 0, m_s0 = 0, m_s1 = 0, m_bank = 1;

    function automatic int m_asleep();
        return (mf_mode == 2'd1 && m_pin == 0) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        int pe, req, nb, n0, n1, ns0, ns1;
        int nrc, nrd, nsc, nsd, nrh, nmh;
        if (rst) begin
            m_pin = 1; m_rs = 0; m_rp = 0; m_ss = 0; m_sp = 0;
            m_rcnt = 0; m_rdiv = 0; m_scnt = 0; m_sdiv = 0; m_rh = 0; m_mh = 0;
            m_c0 = 0; m_c0p = 0; m_c1 = 0; m_s0 = 0; m_s1 = 0; m_bank = 1;
        end else begin
            pe = m_bank ? int'(b1_post) : int'(b0_post);
            if (pe == 0) pe = 1;
            req = (mf_mode == 2'd2) ? m_pin : 1;
            nb = m_c0 ? m_bank : req;
            if (m_asleep() == 1) begin
                nrc = 0; nrd = 0; nsc = 0; nsd = 0; nrh = 0; nmh = 0;
                n0 = 0; n1 = 0; ns0 = 0; ns1 = 0;
            end else begin
                ns0 = m_c0 ? m_s0 : (m_bank ? int'(b1_msel) : int'(b0_msel));
                ns1 = m_c1 ? m_s1 : (m_bank ? int'(b1_asel) : int'(b0_asel));
                n0 = (m_s0 == 1) ? m_rs : (m_s0 == 2) ? m_rdiv : m_sdiv;
                n1 = (m_s1 == 0) ? m_rs : (m_s1 == 1) ? m_rh : (m_s1 == 2) ? m_c0 : m_mh;
                nrc = m_rcnt; nrd = m_rdiv; nsc = m_scnt; nsd = m_sdiv; nrh = m_rh; nmh = m_mh;
                if (m_rs == 1 && m_rp == 0) begin
                    nrh = 1 - m_rh;
                    if (m_rcnt + 1 >= pe) begin nrc = 0; nrd = 1 - m_rdiv; end
                    else nrc = m_rcnt + 1;
                end
                if (m_ss == 1 && m_sp == 0) begin
                    if (m_scnt + 1 >= pe) begin nsc = 0; nsd = 1 - m_sdiv; end
                    else nsc = m_scnt + 1;
                end
                if (m_c0 == 1 && m_c0p == 0) nmh = 1 - m_mh;
            end
            m_rcnt = nrc; m_rdiv = nrd; m_scnt = nsc; m_sdiv = nsd; m_rh = nrh; m_mh = nmh;
            m_c0p = m_c0; m_c0 = n0; m_c1 = n1; m_s0 = ns0; m_s1 = ns1; m_bank = nb;
            m_rp = m_rs; m_rs = int'(ref_in); m_sp = m_ss; m_ss = int'(syn_in);
            m_pin = int'(mf_pin);
        end
    end

    // compare against the model away from the active edge
    always @(negedge clk) begin
        if (!rst && !ended) begin
            check("R3,R8 main_clk", int'(main_clk), m_c0);
            check("R4,R8 aux_clk", int'(aux_clk), m_c1);
            check("R5,R6 main_clk_en", int'(main_clk_en),
                  (m_asleep() == 1) ? 0 : ((mf_mode == 2'd0) ? m_pin : 1));
            check("R4 aux_clk_en", int'(aux_clk_en), (mf_mode == 2'd3) ? 1 : 0);
            check("R6 pll_sleep", int'(pll_sleep), m_asleep());
            check("R7,R9 active_bank", int'(active_bank), m_bank);
            check("R7 pll_pre_div", int'(pll_pre_div), m_bank ? int'(b1_pre) : int'(b0_pre));
            check("R7 pll_fb_div", int'(pll_fb_div), m_bank ? int'(b1_fb) : int'(b0_fb));
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #3;
    endtask

    // counts high samples and rising edges of main or aux over a window
    task automatic window(input bit use_aux, input int len, output int highs, output int rises);
        int prev;
        highs = 0; rises = 0;
        prev = use_aux ? int'(aux_clk) : int'(main_clk);
        for (int i = 0; i < len; i++) begin
            int cur;
            step(1);
            cur = use_aux ? int'(aux_clk) : int'(main_clk);
            highs += cur;
            if (cur == 1 && prev == 0) rises++;
            prev = cur;
        end
    endtask

    initial begin
        int h, r;
        step(5);
        rst = 1'b0;
        step(1);
        // R10: state right after reset
        check("R10 main_clk low", int'(main_clk), 0);
        check("R10 aux_clk low", int'(aux_clk), 0);
        check("R10 active_bank", int'(active_bank), 1);
        check("R10 pll_sleep", int'(pll_sleep), 0);

        // R1: ref divided by 2*3, ref period 4 -> output period 24
        step(100);
        window(0, 240, h, r);
        check("R1 high cycles P=3", h, 120);
        check("R1 rising edges P=3", r, 10);

        // R2: P=0 acts as P=1 -> period 8
        b1_post = 14'd0;
        step(60);
        window(0, 80, h, r);
        check("R2 high cycles P=0", h, 40);
        check("R2 rising edges P=0", r, 10);

        // R3: raw reference, then synthesized divided by 2*2 (period 24)
        b1_msel = 2'd1;
        step(40);
        window(0, 40, h, r);
        check("R3 raw ref high cycles", h, 20);
        b1_post = 14'd2; b1_msel = 2'd0;
        step(100);
        window(0, 240, h, r);
        check("R3 syn div high cycles", h, 120);
        check("R3 syn div rising edges", r, 10);
        b1_msel = 2'd3;
        step(100);
        window(0, 240, h, r);
        check("R3 select 3 high cycles", h, 120);

        // R5: enable mode
        mf_pin = 1'b0;
        step(2);
        check("R5 enable low", int'(main_clk_en), 0);
        check("R5 aux stays off", int'(aux_clk_en), 0);
        mf_pin = 1'b1;
        step(2);
        check("R5 enable high", int'(main_clk_en), 1);

        // R4: secondary clock mode
        mf_mode = 2'd3;
        b1_asel = 2'd1;
        step(60);
        check("R4 aux enable", int'(aux_clk_en), 1);
        window(1, 80, h, r);
        check("R4 ref half high cycles", h, 40);
        b1_msel = 2'd1; b1_asel = 2'd3;
        step(60);
        window(1, 80, h, r);
        check("R4 main half high cycles", h, 40);
        b1_asel = 2'd2;
        step(40);
        b1_asel = 2'd0;
        step(40);

        // R9: pin has no control role in mode 3
        mf_pin = 1'b0;
        step(5);
        check("R9 enable kept", int'(main_clk_en), 1);
        check("R9 no sleep", int'(pll_sleep), 0);
        check("R9 bank kept", int'(active_bank), 1);
        mf_pin = 1'b1;

        // R6: sleep mode
        mf_mode = 2'd1; b1_msel = 2'd2; b1_post = 14'd3;
        step(50);
        mf_pin = 1'b0;
        step(3);
        check("R6 sleep raised", int'(pll_sleep), 1);
        check("R6 main enable off", int'(main_clk_en), 0);
        window(0, 20, h, r);
        check("R6 main quiet", h, 0);
        mf_pin = 1'b1;
        step(1);
        check("R6 sleep released", int'(pll_sleep), 0);
        check("R6 main starts low", int'(main_clk), 0);
        step(60);

        // R7: bank select
        mf_mode = 2'd2; b0_post = 14'd1; b0_msel = 2'd2;
        mf_pin = 1'b0;
        step(60);
        check("R7 bank 0 taken", int'(active_bank), 0);
        check("R7 pre div bank 0", int'(pll_pre_div), 3);
        check("R7 fb div bank 0", int'(pll_fb_div), 40);
        window(0, 80, h, r);
        check("R7 bank 0 period", h, 40);
        mf_pin = 1'b1;
        step(60);
        check("R7 bank 1 back", int'(active_bank), 1);

        // R7/R8: random bank flips and source changes under the model
        for (int k = 0; k < 60; k++) begin
            mf_pin = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 3) == 0) b0_msel = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 3) == 0) b1_msel = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 4) == 0) b0_post = 14'($urandom_range(0, 3));
            step(int'($urandom_range(3, 30)));
        end
        mf_mode = 2'd3;
        for (int k = 0; k < 40; k++) begin
            b1_asel = 2'($urandom_range(0, 3));
            b1_msel = 2'($urandom_range(0, 3));
            step(int'($urandom_range(3, 25)));
        end
        mf_mode = 2'd1;
        for (int k = 0; k < 20; k++) begin
            mf_pin = 1'($urandom_range(0, 1));
            step(int'($urandom_range(2, 20)));
        end
        mf_pin = 1'b1;
        step(20);
        finish_run();
    end

    initial begin
        #(CLK_P * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

endmodule